// File: doc/BRIEF.md
# Dual-Clock Shift-and-Latch Output Register

This block turns a serial bit stream into a parallel word for output expansion, for example driving LED rows or seven-segment digits from a few control pins. Bits enter on a serial data pin. Each rising edge of the shift clock moves them one stage along a chain of stages. A second, independent clock copies the whole chain into a storage register, which drives the parallel outputs. Because of this split, new data can be shifted in while the outputs keep showing the previous word. The outputs then change all together on a single storage clock edge.

Each of the two register banks has its own active-low asynchronous clear. The bit at the far end of the shift chain is brought out as a cascade pin. That pin can feed the serial input of another instance, so that several instances form one longer chain. If the two clocks are tied together, the storage register captures the chain as it stood before that same edge. The outputs therefore trail the chain by one shift.

The pins are plain clocked control pins. There is no valid/ready handshake, because the protocol is defined by clock edges alone.

Top module: `shift_latch_expander`

## Requirements
- R1: While both clears are low, every parallel output and the cascade output are 0.
- R2: On a rising shift clock with the shift clear high, stage 0 takes the serial input and each stage i (i > 0) takes the old value of stage i-1.
- R3: A low shift clear empties every shift stage at once, without any clock, and the shift clock has no effect while it stays low. The cascade output reads 0 and a later storage clock loads 0.
- R4: A low storage clear forces the parallel outputs to 0 at once. While it stays low, storage clock edges have no effect, and the outputs remain 0 after it is released until the next storage clock edge.
- R5: A rising storage clock copies the shift stages into the parallel outputs, with stage i driving par_q[i]. Between storage clock edges the parallel outputs hold their value, even while shift edges occur.
- R6: Without a rising shift clock, and with the shift clear high, the shift stages keep their contents, so repeated storage clock edges load the same word.
- R7: The cascade output always equals the last shift stage. It is unaffected by the storage clock and the storage clear. Feeding it into a second instance's serial input forms one chain of twice the width.
- R8: With both clocks driven from one signal, each edge loads the storage register with the shift contents from before that edge, so the outputs lag the chain by exactly one shift.
- R9: Bit order: output A is par_q[0] (stage 0) and output H is par_q[WIDTH-1]. After WIDTH shifts, the first bit shifted in appears on par_q[WIDTH-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data, taken into stage 0 on a rising shift clock |
| shclk | input | 1 | Shift clock, rising-edge active |
| sh_clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| stclk | input | 1 | Storage clock, rising-edge active |
| st_clr_n | input | 1 | Asynchronous clear of the storage register, active low |
| par_q | output | WIDTH | Latched parallel outputs; bit 0 is output A |
| cas_out | output | 1 | Cascade output, the last shift stage |

## Verification
The bench builds the block with the default WIDTH of 8. It uses two instances chained through the cascade pin, so a 16-bit word can show that bits flow across the device boundary in order. With 8 stages, a walked single bit reaches output H in a few cycles, and an exhaustive byte pattern table stays short. The width is still large enough that bit-order mistakes between the low and high ends are visible.

// File: rtl/shift_latch_pkg.sv
package shift_latch_pkg;
  localparam int unsigned DEFAULT_WIDTH = 8;
  localparam int unsigned MIN_WIDTH     = 2;
endpackage

// File: rtl/sl_shift_stage.sv
module sl_shift_stage #(
  parameter int unsigned WIDTH = shift_latch_pkg::DEFAULT_WIDTH
) (
  input  logic             shclk,
  input  logic             sh_clr_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages
);
  localparam int unsigned LAST = WIDTH - 1;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_stage
      logic d_in;
      if (g == 0) begin : g_head
        assign d_in = ser_in;
      end else begin : g_body
        assign d_in = stages[g-1];
      end
      always_ff @(posedge shclk or negedge sh_clr_n) begin
        if (!sh_clr_n) stages[g] <= 1'b0;
        else           stages[g] <= d_in;
      end
    end
  endgenerate

  initial begin
    if (LAST + 1 < shift_latch_pkg::MIN_WIDTH) $display("width below minimum");
  end
endmodule

// File: rtl/sl_store_stage.sv
module sl_store_stage #(
  parameter int unsigned WIDTH = shift_latch_pkg::DEFAULT_WIDTH
) (
  input  logic             stclk,
  input  logic             st_clr_n,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] held
);
  always_ff @(posedge stclk or negedge st_clr_n) begin
    if (!st_clr_n) held <= '0;
    else           held <= load_val;
  end
endmodule

// File: rtl/shift_latch_expander.sv
module shift_latch_expander #(
  parameter int unsigned WIDTH = shift_latch_pkg::DEFAULT_WIDTH
) (
  input  logic             ser_in,
  input  logic             shclk,
  input  logic             sh_clr_n,
  input  logic             stclk,
  input  logic             st_clr_n,
  output logic [WIDTH-1:0] par_q,
  output logic             cas_out
);
  localparam int unsigned TAIL = WIDTH - 1;

  logic [WIDTH-1:0] sh_bits;

  sl_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .shclk    (shclk),
    .sh_clr_n (sh_clr_n),
    .ser_in   (ser_in),
    .stages   (sh_bits)
  );

  sl_store_stage #(.WIDTH(WIDTH)) u_store (
    .stclk    (stclk),
    .st_clr_n (st_clr_n),
    .load_val (sh_bits),
    .held     (par_q)
  );

  assign cas_out = sh_bits[TAIL];
endmodule

// File: rtl/shift_latch_expander_chk.sv
module shift_latch_expander_chk #(
  parameter int unsigned WIDTH = shift_latch_pkg::DEFAULT_WIDTH
) (
  input logic             ser_in,
  input logic             shclk,
  input logic             sh_clr_n,
  input logic             stclk,
  input logic             st_clr_n,
  input logic [WIDTH-1:0] par_q,
  input logic             cas_out,
  input logic [WIDTH-1:0] shreg
);
  logic sh_armed;
  logic st_armed;

  always_ff @(posedge shclk or negedge sh_clr_n) begin
    if (!sh_clr_n) sh_armed <= 1'b0;
    else           sh_armed <= 1'b1;
  end

  always_ff @(posedge stclk or negedge st_clr_n) begin
    if (!st_clr_n) st_armed <= 1'b0;
    else           st_armed <= 1'b1;
  end

  assert_shift_move_R2: assert property (@(posedge shclk) disable iff (!sh_clr_n)
    sh_armed |-> (shreg[WIDTH-1:1] == $past(shreg[WIDTH-2:0])) && (shreg[0] == $past(ser_in)));

  assert_shift_clear_R3: assert property (@(posedge stclk) disable iff (!st_clr_n)
    !sh_clr_n |=> par_q == '0);

  assert_store_clear_R4: assert property (@(posedge shclk) disable iff (!sh_clr_n)
    !st_clr_n |-> par_q == '0);

  assert_store_load_R5: assert property (@(posedge stclk) disable iff (!st_clr_n)
    st_armed |-> par_q == $past(shreg));

  assert_cascade_tail_R7: assert property (@(posedge shclk) disable iff (!sh_clr_n)
    sh_armed |-> cas_out == $past(shreg[WIDTH-2]));
endmodule

bind shift_latch_expander shift_latch_expander_chk #(.WIDTH(WIDTH)) u_chk (
  .ser_in   (ser_in),
  .shclk    (shclk),
  .sh_clr_n (sh_clr_n),
  .stclk    (stclk),
  .st_clr_n (st_clr_n),
  .par_q    (par_q),
  .cas_out  (cas_out),
  .shreg    (sh_bits)
);

// File: tb/shift_latch_expander_tb.sv
module shift_latch_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int NVEC = 6;
  // {shifted byte (bit 7 first), expected par_q, expected cas_out}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'hA5, 8'hA5, 1'b1},
    {8'h3C, 8'h3C, 1'b0},
    {8'h01, 8'h01, 1'b0},
    {8'h80, 8'h80, 1'b1},
    {8'hFF, 8'hFF, 1'b1},
    {8'h00, 8'h00, 1'b0}
  };

  logic ser_in, shclk, sh_clr_n, stclk, st_clr_n;
  logic [7:0] q0, q1;
  logic c0, c1;
  int total, bad;
  bit done;

  shift_latch_expander #(.WIDTH(8)) u_dut (
    .ser_in(ser_in), .shclk(shclk), .sh_clr_n(sh_clr_n),
    .stclk(stclk), .st_clr_n(st_clr_n), .par_q(q0), .cas_out(c0));

  shift_latch_expander #(.WIDTH(8)) u_dut2 (
    .ser_in(c0), .shclk(shclk), .sh_clr_n(sh_clr_n),
    .stclk(stclk), .st_clr_n(st_clr_n), .par_q(q1), .cas_out(c1));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sh_bit(input logic b);
    ser_in = b; #HALF; shclk = 1'b1; #HALF; shclk = 1'b0; #1;
  endtask

  task automatic latch();
    #HALF; stclk = 1'b1; #HALF; stclk = 1'b0; #1;
  endtask

  task automatic tied(input logic b);
    ser_in = b; #HALF; shclk = 1'b1; stclk = 1'b1; #HALF; shclk = 1'b0; stclk = 1'b0; #1;
  endtask

  task automatic shift_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) sh_bit(d[i]);
  endtask

  task automatic clear_all();
    sh_clr_n = 1'b0; st_clr_n = 1'b0; #HALF; sh_clr_n = 1'b1; st_clr_n = 1'b1; #HALF;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    total = 0; bad = 0; done = 0;
    ser_in = 0; shclk = 0; stclk = 0; sh_clr_n = 0; st_clr_n = 0;
    #CLK_PERIOD;
    chk("R1 par_q", {8'h0, q0}, 16'h0);
    chk("R1 cas_out", {15'h0, c0}, 16'h0);
    sh_clr_n = 1; st_clr_n = 1; #HALF;

    prev = 8'h00;
    for (int v = 0; v < NVEC; v++) begin
      shift_byte(VEC[v][16:9]);
      chk("R5 hold before latch", {8'h0, q0}, {8'h0, prev});
      chk("R7 cascade after byte", {15'h0, c0}, {15'h0, VEC[v][0]});
      latch();
      chk("R9 R5 latched byte", {8'h0, q0}, {8'h0, VEC[v][8:1]});
      prev = VEC[v][8:1];
    end

    // R3: clear overrides shift clock
    shift_byte(8'hFF);
    sh_clr_n = 0; #1;
    chk("R3 cascade cleared", {15'h0, c0}, 16'h0);
    sh_bit(1'b1);
    chk("R3 shift ignored in clear", {15'h0, c0}, 16'h0);
    sh_clr_n = 1; #1;
    latch();
    chk("R3 load after clear", {8'h0, q0}, 16'h0);

    // R9: bit order
    sh_bit(1'b1);
    latch();
    chk("R9 one shift", {8'h0, q0}, 16'h0001);
    for (int i = 0; i < 7; i++) sh_bit(1'b0);
    latch();
    chk("R9 first bit on H", {8'h0, q0}, 16'h0080);

    // R6: no shift, repeat loads
    latch();
    chk("R6 reload 1", {8'h0, q0}, 16'h0080);
    latch();
    chk("R6 reload 2", {8'h0, q0}, 16'h0080);

    // R4: storage clear
    shift_byte(8'hFF);
    latch();
    chk("R4 preload", {8'h0, q0}, 16'h00FF);
    st_clr_n = 0; #1;
    chk("R4 immediate clear", {8'h0, q0}, 16'h0);
    chk("R7 cascade ignores storage clear", {15'h0, c0}, 16'h0001);
    latch();
    chk("R4 clock ignored", {8'h0, q0}, 16'h0);
    st_clr_n = 1; #1;
    chk("R4 held after release", {8'h0, q0}, 16'h0);
    latch();
    chk("R6 shift held through storage clear", {8'h0, q0}, 16'h00FF);
    chk("R7 cascade ignores storage clock", {15'h0, c0}, 16'h0001);

    // R8: tied clocks
    clear_all();
    tied(1'b1); tied(1'b1); tied(1'b1);
    chk("R8 lag after three", {8'h0, q0}, 16'h0003);
    tied(1'b0);
    chk("R8 lag after four", {8'h0, q0}, 16'h0007);

    // R7: chaining two instances
    clear_all();
    for (int i = 15; i >= 0; i--) sh_bit(16'hC35A >> i);
    latch();
    chk("R7 chain low device", {8'h0, q0}, 16'h005A);
    chk("R7 chain high device", {8'h0, q1}, 16'h00C3);
    chk("R7 chain tail", {15'h0, c1}, 16'h0001);
    chk("R7 chain mid", {15'h0, c0}, 16'h0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule